// File: doc/BRIEF.md
# Periodic Sensor Sample Encryptor

This block samples a slow analog sensor on a fixed schedule without any software involvement, and encrypts each reading. An interval timer counts a programmable number of clock cycles. When the count runs out, a sequencer asks an ADC-style read port for a conversion and waits for the converter to report that data is ready. It then packs the 12-bit reading, together with a running sample index, into a 128-bit plaintext block. The block goes to an external block-cipher core through a start/done handshake, with the core's mode pinned to encrypt. The ciphertext that comes back lands in an output register.

A consumer reads that register through a valid/acknowledge pair. When a new result arrives before the previous one has been acknowledged, the new result replaces the old one and an overrun flag is raised. A 32-bit counter of completed samples is exported. The cipher key is not handled here: the core takes it from a key register elsewhere in the chip. The default interval is 500,000,000 cycles, which is five seconds at a 100 MHz clock.

Top module: `sample_sealer`

## Requirements
- R1: After reset, `adc_req_o`, `aes_start_o`, `res_valid_o` and `res_overrun_o` are 0, and `sample_count_o` is 0.
- R2: `adc_req_o` is a one-cycle pulse. Once a result has been stored (the clock edge at which `sample_count_o` increments), the next pulse is high exactly `PERIOD_CYCLES` clock cycles after that edge.
- R3: After a request, the block waits for `adc_rdy_i` with no time limit, and starts no encryption until the conversion has completed.
- R4: The plaintext `aes_block_o` carries the sample in bits 11:0 and the number of samples completed before this one in bits 63:32. Every other bit is 0.
- R5: `aes_start_o` is a one-cycle pulse. `aes_encrypt_o` reads 1 when the pulse is issued. `aes_block_o` holds steady until `aes_done_i`.
- R6: `aes_result_i` is captured in the cycle in which `aes_done_i` is high. Two clock edges after that cycle, it appears on `res_data_o` with `res_valid_o` set.
- R7: `res_valid_o` and `res_data_o` hold until `res_ack_i` is seen. An acknowledge clears `res_valid_o`.
- R8: A new result stored while `res_valid_o` is still set, with no acknowledge in that cycle, replaces `res_data_o` and sets `res_overrun_o`. `res_overrun_o` stays set until an acknowledge clears it.
- R9: `sample_count_o` increases by exactly one for each completed sample, at the same edge at which the result is stored.
- R10: `adc_data_i` is taken only in the cycle in which `adc_rdy_i` is high. Values present at any other time have no effect on the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_req_o | output | 1 | Conversion request pulse |
| adc_rdy_i | input | 1 | Conversion data ready |
| adc_data_i | input | 12 | Conversion result |
| aes_start_o | output | 1 | Cipher core start pulse |
| aes_encrypt_o | output | 1 | Cipher mode, always 1 (encrypt) |
| aes_block_o | output | 128 | Padded plaintext block |
| aes_done_i | input | 1 | Cipher core done |
| aes_result_i | input | 128 | Ciphertext from the core |
| res_valid_o | output | 1 | Stored result is unread |
| res_data_o | output | 128 | Stored ciphertext |
| res_ack_i | input | 1 | Consumer acknowledge |
| res_overrun_o | output | 1 | Unread result was overwritten |
| sample_count_o | output | 32 | Completed sample count |

## Verification
The bench builds the block with `PERIOD_CYCLES` set to 40, so eight full sample cycles, each with a measured request interval, fit into a few hundred clocks. At that period, a converter latency of 40 cycles and a held acknowledge over two consecutive samples both fit in one short run. This makes the overrun path and the long-wait path reachable. Converter latencies range from 1 to 40 cycles and core latencies from 1 to 10, and the samples include 0 and 4095.

// File: rtl/sealer_pkg.sv
package sealer_pkg;

  localparam int SAMPLE_W = 12;
  localparam int BLOCK_W  = 128;
  localparam int CNT_W    = 32;
  localparam int CNT_LSB  = 32;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ADC_REQ   = 3'd1,
    ST_ADC_WAIT  = 3'd2,
    ST_ENC_START = 3'd3,
    ST_ENC_WAIT  = 3'd4,
    ST_STORE     = 3'd5
  } seq_state_e;

  // Plaintext layout: sample at the bottom, sample index in the upper word
  // of the low half, zeros elsewhere.
  function automatic logic [BLOCK_W-1:0] pad_block(
    input logic [SAMPLE_W-1:0] sample,
    input logic [CNT_W-1:0]    index
  );
    logic [BLOCK_W-1:0] blk;
    blk                      = '0;
    blk[SAMPLE_W-1:0]        = sample;
    blk[CNT_LSB +: CNT_W]    = index;
    return blk;
  endfunction

endpackage

// File: rtl/sealer_timer.sv
module sealer_timer #(
  parameter int PERIOD_CYCLES = 500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expired_o
);
  localparam int TW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (!expired_o)   cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !expired_o);  // R2

endmodule

// File: rtl/sealer_seq.sv
module sealer_seq
  import sealer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  output logic                adc_req_o,
  input  logic                adc_rdy_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                aes_start_o,
  output logic [BLOCK_W-1:0]  aes_block_o,
  input  logic                aes_done_i,
  input  logic [BLOCK_W-1:0]  aes_result_i,
  output logic                store_o,
  output logic [BLOCK_W-1:0]  cipher_o,
  output logic [CNT_W-1:0]    count_o
);
  seq_state_e          state_q;
  logic [SAMPLE_W-1:0] sample_q;
  logic [BLOCK_W-1:0]  cipher_q;
  logic [CNT_W-1:0]    count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sample_q <= '0;
      cipher_q <= '0;
      count_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE:      if (tick_i) state_q <= ST_ADC_REQ;
        ST_ADC_REQ:   state_q <= ST_ADC_WAIT;
        ST_ADC_WAIT:  if (adc_rdy_i) begin
                        sample_q <= adc_data_i;
                        state_q  <= ST_ENC_START;
                      end
        ST_ENC_START: state_q <= ST_ENC_WAIT;
        ST_ENC_WAIT:  if (aes_done_i) begin
                        cipher_q <= aes_result_i;
                        state_q  <= ST_STORE;
                      end
        ST_STORE:     begin
                        count_q <= count_q + 1'b1;
                        state_q <= ST_IDLE;
                      end
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_req_o   = (state_q == ST_ADC_REQ);
  assign aes_start_o = (state_q == ST_ENC_START);
  assign store_o     = (state_q == ST_STORE);
  assign aes_block_o = pad_block(sample_q, count_q);
  assign cipher_o    = cipher_q;
  assign count_o     = count_q;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req_o |=> !adc_req_o);  // R2
  AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_req_o) |-> $past(tick_i));  // R2
  AST_START_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    aes_start_o |-> $past(adc_rdy_i));  // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    aes_start_o |=> !aes_start_o);  // R5
  AST_BLOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ENC_WAIT) |-> $stable(aes_block_o));  // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |=> (count_o == $past(count_o) + 1'b1));  // R9
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !store_o |=> $stable(count_o));  // R9

endmodule

// File: rtl/sealer_outbuf.sv
module sealer_outbuf
  import sealer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store_i,
  input  logic [BLOCK_W-1:0] data_i,
  input  logic               ack_i,
  output logic               valid_o,
  output logic [BLOCK_W-1:0] data_o,
  output logic               overrun_o
);
  logic               valid_q, overrun_q;
  logic [BLOCK_W-1:0] data_q;
  logic               lost_w;

  // An unread result is lost when a new one lands without an acknowledge.
  assign lost_w = store_i && valid_q && !ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      overrun_q <= 1'b0;
      data_q    <= '0;
    end else begin
      if (store_i) data_q <= data_i;
      if (store_i)    valid_q <= 1'b1;
      else if (ack_i) valid_q <= 1'b0;
      if (lost_w)     overrun_q <= 1'b1;
      else if (ack_i) overrun_q <= 1'b0;
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign overrun_o = overrun_q;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ack_i && !store_i) |=> (valid_o && $stable(data_o)));  // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !store_i) |=> !valid_o);  // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && valid_o && !ack_i) |=> (overrun_o && valid_o));  // R8
  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !store_i) |=> !overrun_o);  // R8

endmodule

// File: rtl/sample_sealer.sv
module sample_sealer
  import sealer_pkg::*;
#(
  parameter int PERIOD_CYCLES = 500_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                adc_req_o,
  input  logic                adc_rdy_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                aes_start_o,
  output logic                aes_encrypt_o,
  output logic [BLOCK_W-1:0]  aes_block_o,
  input  logic                aes_done_i,
  input  logic [BLOCK_W-1:0]  aes_result_i,
  output logic                res_valid_o,
  output logic [BLOCK_W-1:0]  res_data_o,
  input  logic                res_ack_i,
  output logic                res_overrun_o,
  output logic [CNT_W-1:0]    sample_count_o
);
  logic               tick_w;
  logic               store_w;
  logic [BLOCK_W-1:0] cipher_w;

  assign aes_encrypt_o = 1'b1;

  sealer_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (store_w),
    .expired_o (tick_w)
  );

  sealer_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_w),
    .adc_req_o    (adc_req_o),
    .adc_rdy_i    (adc_rdy_i),
    .adc_data_i   (adc_data_i),
    .aes_start_o  (aes_start_o),
    .aes_block_o  (aes_block_o),
    .aes_done_i   (aes_done_i),
    .aes_result_i (aes_result_i),
    .store_o      (store_w),
    .cipher_o     (cipher_w),
    .count_o      (sample_count_o)
  );

  sealer_outbuf outbuf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_i   (store_w),
    .data_i    (cipher_w),
    .ack_i     (res_ack_i),
    .valid_o   (res_valid_o),
    .data_o    (res_data_o),
    .overrun_o (res_overrun_o)
  );

  AST_RESULT_WITH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_count_o != $past(sample_count_o)) |-> res_valid_o);  // R6

endmodule

// File: tb/sample_sealer_tb_top.sv
`timescale 1ns/1ps
module sample_sealer_tb_top;
  localparam int P = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         adc_req_o, adc_rdy_i = 1'b0;
  logic [11:0]  adc_data_i = 12'h0;
  logic         aes_start_o, aes_encrypt_o, aes_done_i = 1'b0;
  logic [127:0] aes_block_o, aes_result_i = '0;
  logic         res_valid_o, res_ack_i = 1'b0, res_overrun_o;
  logic [127:0] res_data_o;
  logic [31:0]  sample_count_o;

  always #2 clk = ~clk;

  sample_sealer #(.PERIOD_CYCLES(P)) dut_i (.*);

  int checks = 0, errors = 0;
  int cyc = 0;
  int store_cyc = 0, done_cyc = 0;
  bit have_store = 1'b0;
  bit hold = 1'b0;
  int nreq = 0, nenc = 0;
  int sq[$];
  logic [127:0] eq[$];

  int lat_adc[8] = '{26, 1, 5, 26, 40, 2, 26, 3};
  int lat_aes[8] = '{10, 1, 3, 7, 2, 5, 1, 4};
  logic [11:0] smp[8] = '{12'h000, 12'hFFF, 12'h5A3, 12'h001,
                          12'h800, 12'hABC, 12'h7FF, 12'h123};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_pad(input logic [11:0] s, input int idx);
    return {64'h0, 32'(idx), 20'h0, s};
  endfunction

  function automatic logic [127:0] scramble(input logic [127:0] b);
    return {b[63:0], b[127:64]} ^ 128'hC3A5_5A3C_0F1E_2D4B_9687_7869_F0E1_D2C3;
  endfunction

  // ADC model (driver): answers requests after a chosen latency.
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (adc_req_o) begin
        int k;
        k = nreq;
        if (have_store)
          check(cyc - store_cyc == P, "R2 request interval", 128'(cyc - store_cyc), 128'(P));
        nreq++;
        for (int i = 0; i < lat_adc[k]; i++) begin
          @(negedge clk);
          check(!aes_start_o, "R3 no start before ready", 128'(aes_start_o), 128'h0);
          check(!adc_req_o, "R2 request is one pulse", 128'(adc_req_o), 128'h0);
        end
        adc_rdy_i  = 1'b1;
        adc_data_i = smp[k];
        sq.push_back(int'(smp[k]));
        @(negedge clk);
        adc_rdy_i  = 1'b0;
        adc_data_i = 12'hE5E ^ 12'(k * 37);  // R10: junk while not ready
      end else begin
        adc_data_i = ~adc_data_i;  // R10: junk changes while idle
      end
    end
  end

  // Cipher core model: checks the plaintext, returns a scrambled block.
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (aes_start_o) begin
        logic [127:0] ep, held;
        int k, s;
        k = nenc;
        nenc++;
        check(aes_encrypt_o == 1'b1, "R5 encrypt mode", 128'(aes_encrypt_o), 128'h1);
        s = sq.pop_front();
        ep = exp_pad(12'(s), k);
        check(aes_block_o == ep, "R4 padded block", aes_block_o, ep);
        check(aes_block_o == ep, "R10 sample taken only on ready", aes_block_o, ep);
        held = aes_block_o;
        for (int i = 0; i < lat_aes[k]; i++) begin
          @(negedge clk);
          check(!aes_start_o, "R5 start is one pulse", 128'(aes_start_o), 128'h0);
          check(aes_block_o == held, "R5 block stable", aes_block_o, held);
        end
        aes_done_i   = 1'b1;
        aes_result_i = scramble(ep);
        eq.push_back(scramble(ep));
        done_cyc = cyc;
        @(negedge clk);
        aes_done_i   = 1'b0;
        aes_result_i = ~aes_result_i;
      end
    end
  end

  // Monitor: pops the expected ciphertext when the count moves.
  initial begin
    int prevc;
    prevc = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (sample_count_o != 32'(prevc)) begin
        logic [127:0] e;
        check(sample_count_o == 32'(prevc + 1), "R9 count step", 128'(sample_count_o), 128'(prevc + 1));
        check(res_valid_o, "R6 valid with result", 128'(res_valid_o), 128'h1);
        check(cyc - done_cyc == 2, "R6 result latency", 128'(cyc - done_cyc), 128'h2);
        e = (eq.size() > 0) ? eq.pop_front() : '0;
        check(res_data_o == e, "R6 ciphertext", res_data_o, e);
        store_cyc  = cyc;
        have_store = 1'b1;
        prevc = int'(sample_count_o);
      end
      res_ack_i = !hold && res_valid_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!adc_req_o && !aes_start_o, "R1 idle controls", {adc_req_o, aes_start_o}, 128'h0);
    check(!res_valid_o && !res_overrun_o, "R1 result flags", {res_valid_o, res_overrun_o}, 128'h0);
    check(sample_count_o == 0, "R1 count", 128'(sample_count_o), 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sample_count_o == 0 && !res_valid_o, "R1 after release", 128'(sample_count_o), 128'h0);

    wait (sample_count_o == 5);
    repeat (3) @(negedge clk);
    check(!res_valid_o, "R7 ack clears valid", 128'(res_valid_o), 128'h0);
    hold = 1'b1;
    wait (sample_count_o == 6);
    @(negedge clk);
    check(res_valid_o && !res_overrun_o, "R7 held result, no overrun yet",
          {res_valid_o, res_overrun_o}, 128'h2);
    begin
      logic [127:0] d;
      d = res_data_o;
      repeat (10) begin
        @(negedge clk);
        check(res_valid_o && res_data_o == d, "R7 valid and data hold", res_data_o, d);
      end
    end
    wait (sample_count_o == 7);
    @(negedge clk);
    check(res_overrun_o, "R8 overrun set", 128'(res_overrun_o), 128'h1);
    check(res_valid_o, "R8 still valid after overwrite", 128'(res_valid_o), 128'h1);
    hold = 1'b0;
    repeat (2) @(negedge clk);
    check(!res_valid_o && !res_overrun_o, "R8 ack clears overrun",
          {res_valid_o, res_overrun_o}, 128'h0);
    wait (sample_count_o == 8);
    repeat (3) @(negedge clk);
    check(eq.size() == 0, "R9 all results seen", 128'(eq.size()), 128'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule